// File: doc/BRIEF.md
# Shift Unit with Condition Flags

This unit performs the bit-shift operations of a CISC-style integer core. One instruction word and its operands go in; one clock later it returns the shifted value, a byte-lane write mask, and five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C). It handles byte, word and long operands, left and right shifts, and arithmetic and logical types. A separate single-bit form shifts a 16-bit memory word by one position.

The shift count has two sources. A 3-bit immediate field can encode 1 to 8, with an encoded zero meaning eight. A 32-bit count register supplies a count that is reduced modulo 64, so a count can be larger than the operand width and push every bit out. The X flag is internal state: it takes the new carry only when the count is non-zero. A mode input selects how V behaves on arithmetic left shifts. With the input high, V reports any change of the sign bit during the shift. With it low, V is always cleared.

The core places `result_o` into its destination register using `wmask_o`, so for the smaller sizes only the low byte or word of that register changes.

Top module: `shift_cc_unit`

## Requirements
- R1: Opcode fields are decoded as follows. Bit 8 selects left (1) or right (0). Bit 3 selects logical (1) or arithmetic (0). Bits 7:6 select the size: 00 byte, 01 word, 10 long, 11 single-bit memory form. Bit 5 selects the count source: register (1) or immediate (0). For an immediate count, bits 11:9 give the count, and the value 0 means a count of 8.
- R2: A register count uses only `count_reg_i[5:0]`, so the count is taken modulo 64. Counts at or above the operand width are legal and shift out every bit of the operand.
- R3: The operand is taken at the selected size, and `result_o` is zero above that size. `wmask_o` is 4'b0001 for byte, 4'b0011 for word and memory form, and 4'b1111 for long. N is the top bit of the sized result, and Z is set when the sized result is zero.
- R4: C is the last bit shifted out of the sized operand. When the count is 0, C is 0.
- R5: X takes the new C when the count is non-zero. When the count is 0, X keeps its previous value.
- R6: A right arithmetic shift fills the vacated bits with the sign bit. A right logical shift and every left shift fill them with zeros.
- R7: For an arithmetic left shift with `ovf_mode_i`=1, V is set when the sign bit takes a different value at any step of the shift. For counts at or above the width, this means V is set exactly when the sized operand is non-zero.
- R8: V is 0 for every logical shift and every right shift. V is also 0 for an arithmetic left shift when `ovf_mode_i`=0.
- R9: The memory form shifts the low 16 bits by exactly one. C is bit 15 (left) or bit 0 (right), and X always equals C.
- R10: `done_o` pulses for one cycle, in the cycle after a cycle with `valid_i` high, and the registered outputs update together with it. After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input strobe, one operation per cycle |
| opcode_i | input | 16 | Shift instruction word |
| operand_i | input | 32 | Value to shift |
| count_reg_i | input | 32 | Count register value, used when bit 5 is set |
| ovf_mode_i | input | 1 | 1: arithmetic left shifts report V; 0: V always cleared |
| result_o | output | 32 | Sized shift result, zero above the size |
| wmask_o | output | 4 | Byte-lane write enables for the destination |
| flag_x_o | output | 1 | Extend flag |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |
| done_o | output | 1 | Result valid pulse |

## Verification
The bench covers every count from 0 to 63, for each size, direction and type, in both overflow modes, using operands that stress the sign bit and bits above the size.

- **Counts of 32 to 63:** a unit that wrapped counts modulo 32 would leave data behind in the result.
- **Counts equal to or one past the width:** a wrong carry index returns a stale bit in C instead of the MSB or 0.
- **Zero count:** a unit that always loads X would break the X chain carried from operation to operation.
- **V on shifts of all-ones and of 0x7F-type operands:** a V computed only from the final sign would miss sign flips partway through the shift.
- **Upper-bit garbage on byte and word operands:** a unit that did not mask the operand would let those bits leak into N, Z or C.

// File: rtl/shift_cc_pkg.sv
package shift_cc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_MEM  = 2'b11
  } size_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

endpackage

// File: rtl/shift_cc_decode.sv
module shift_cc_decode
  import shift_cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6,
  localparam int unsigned NB    = DATA_W / 8
) (
  input  logic [15:0]       opcode_i,
  input  logic [DATA_W-1:0] count_reg_i,
  output logic              left_o,
  output logic              logical_o,
  output size_e             size_o,
  output logic              mem_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [NB-1:0]     wmask_o
);

  logic [2:0] imm;

  assign left_o    = opcode_i[8];
  assign logical_o = opcode_i[3];
  assign size_o    = size_e'(opcode_i[7:6]);
  assign mem_o     = (size_o == SZ_MEM);
  assign imm       = opcode_i[11:9];

  always_comb begin
    if (mem_o)            cnt_o = CNT_W'(1);
    else if (opcode_i[5]) cnt_o = count_reg_i[CNT_W-1:0];
    else if (imm == 3'd0) cnt_o = CNT_W'(8);
    else                  cnt_o = CNT_W'(imm);
  end

  // byte lane enables: lane 0 always, lane 1 for word/mem, rest for long
  for (genvar b = 0; b < NB; b++) begin : g_lane
    if (b == 0) begin : g_l0
      assign wmask_o[b] = 1'b1;
    end else if (b == 1) begin : g_l1
      assign wmask_o[b] = (size_o != SZ_BYTE);
    end else begin : g_lh
      assign wmask_o[b] = (size_o == SZ_LONG);
    end
  end

endmodule

// File: rtl/shift_cc_core.sv
module shift_cc_core
  import shift_cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6,
  localparam int unsigned W2    = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] operand_i,
  input  size_e             size_i,
  input  logic              left_i,
  input  logic              logical_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);

  logic [DATA_W-1:0]    mask, op_z, op_x;
  logic                 sign;
  logic [W2-1:0]        lsh;
  logic signed [W2-1:0] rin, rsh;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        mask = DATA_W'(8'hFF);
        sign = operand_i[7];
      end
      SZ_WORD, SZ_MEM: begin
        mask = DATA_W'(16'hFFFF);
        sign = operand_i[15];
      end
      default: begin
        mask = '1;
        sign = operand_i[DATA_W-1];
      end
    endcase
  end

  assign op_z = operand_i & mask;
  assign op_x = (!logical_i && sign) ? (op_z | ~mask) : op_z;

  // wide shifters keep the last bit out in a fixed lane
  assign lsh = {{DATA_W{1'b0}}, op_z} << cnt_i;
  assign rin = {op_x, {DATA_W{1'b0}}};
  assign rsh = logical_i ? (rin >> cnt_i) : (rin >>> cnt_i);

  always_comb begin
    if (left_i) begin
      result_o = lsh[DATA_W-1:0] & mask;
      unique case (size_i)
        SZ_BYTE:         carry_o = lsh[8];
        SZ_WORD, SZ_MEM: carry_o = lsh[16];
        default:         carry_o = lsh[DATA_W];
      endcase
    end else begin
      result_o = rsh[W2-1:DATA_W] & mask;
      carry_o  = rsh[DATA_W-1];
    end
  end

endmodule

// File: rtl/shift_cc_ovf.sv
module shift_cc_ovf
  import shift_cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6,
  localparam int unsigned W2    = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] operand_i,
  input  size_e             size_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              ovf_o
);

  logic [DATA_W-1:0] mask, ext;
  logic              sign;
  logic [W2-1:0]     s_ext, s_shl, hi_mask;
  logic [CNT_W-1:0]  sat_cnt;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        mask    = DATA_W'(8'hFF);
        sign    = operand_i[7];
        hi_mask = {W2{1'b1}} << 7;
      end
      SZ_WORD, SZ_MEM: begin
        mask    = DATA_W'(16'hFFFF);
        sign    = operand_i[15];
        hi_mask = {W2{1'b1}} << 15;
      end
      default: begin
        mask    = '1;
        sign    = operand_i[DATA_W-1];
        hi_mask = {W2{1'b1}} << (DATA_W - 1);
      end
    endcase
  end

  assign ext     = sign ? ((operand_i & mask) | ~mask) : (operand_i & mask);
  assign s_ext   = {{DATA_W{sign}}, ext};
  // saturating the count keeps the compare window inside W2 bits
  assign sat_cnt = (cnt_i > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : cnt_i;
  assign s_shl   = s_ext << sat_cnt;
  assign ovf_o   = |((s_ext ^ s_shl) & hi_mask);

endmodule

// File: rtl/shift_cc_unit.sv
module shift_cc_unit
  import shift_cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(2 * DATA_W),
  localparam int unsigned NB    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [15:0]       opcode_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] count_reg_i,
  input  logic              ovf_mode_i,
  output logic [DATA_W-1:0] result_o,
  output logic [NB-1:0]     wmask_o,
  output logic              flag_x_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              flag_c_o,
  output logic              done_o
);

  logic              left, logical, mem, carry, ovf_raw;
  size_e             size;
  logic [CNT_W-1:0]  cnt;
  logic [NB-1:0]     wmask_d;
  logic [DATA_W-1:0] res_d;
  logic              n_d;
  ccr_t              ccr_d, ccr_q;
  logic [DATA_W-1:0] res_q;
  logic [NB-1:0]     wmask_q;
  logic              done_q;

  shift_cc_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dec (
    .opcode_i    (opcode_i),
    .count_reg_i (count_reg_i),
    .left_o      (left),
    .logical_o   (logical),
    .size_o      (size),
    .mem_o       (mem),
    .cnt_o       (cnt),
    .wmask_o     (wmask_d)
  );

  shift_cc_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .operand_i (operand_i),
    .size_i    (size),
    .left_i    (left),
    .logical_i (logical),
    .cnt_i     (cnt),
    .result_o  (res_d),
    .carry_o   (carry)
  );

  shift_cc_ovf #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ovf (
    .operand_i (operand_i),
    .size_i    (size),
    .cnt_i     (cnt),
    .ovf_o     (ovf_raw)
  );

  always_comb begin
    unique case (size)
      SZ_BYTE:         n_d = res_d[7];
      SZ_WORD, SZ_MEM: n_d = res_d[15];
      default:         n_d = res_d[DATA_W-1];
    endcase
  end

  always_comb begin
    ccr_d.c = carry;
    ccr_d.n = n_d;
    ccr_d.z = (res_d == '0);
    ccr_d.v = ovf_raw & left & ~logical & ovf_mode_i;
    ccr_d.x = (cnt != '0) ? carry : ccr_q.x;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccr_q   <= '0;
      res_q   <= '0;
      wmask_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= valid_i;
      if (valid_i) begin
        ccr_q   <= ccr_d;
        res_q   <= res_d;
        wmask_q <= wmask_d;
      end
    end
  end

  assign result_o = res_q;
  assign wmask_o  = wmask_q;
  assign flag_x_o = ccr_q.x;
  assign flag_n_o = ccr_q.n;
  assign flag_z_o = ccr_q.z;
  assign flag_v_o = ccr_q.v;
  assign flag_c_o = ccr_q.c;
  assign done_o   = done_q;

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  assert_mask_shape_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (wmask_o == NB'(1) || wmask_o == NB'(3) || wmask_o == {NB{1'b1}}));
  assert_nz_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(flag_n_o && flag_z_o));
  assert_zero_cnt_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cnt == '0) |=> !flag_c_o);
  assert_x_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cnt == '0) |=> $stable(flag_x_o));
  assert_v_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (logical || !left || !ovf_mode_i)) |=> !flag_v_o);
  assert_mem_x_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mem) |=> (flag_x_o == flag_c_o));

endmodule

// File: tb/shift_cc_unit_bench.sv
module shift_cc_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] opcode = '0;
  logic [31:0] operand = '0;
  logic [31:0] count_reg = '0;
  logic        ovf_mode = 1'b0;
  logic [31:0] result;
  logic [3:0]  wmask;
  logic        fx, fn, fz, fv, fc, done;

  always #10 clk = ~clk;

  shift_cc_unit u_shift_cc_unit (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .valid_i     (valid),
    .opcode_i    (opcode),
    .operand_i   (operand),
    .count_reg_i (count_reg),
    .ovf_mode_i  (ovf_mode),
    .result_o    (result),
    .wmask_o     (wmask),
    .flag_x_o    (fx),
    .flag_n_o    (fn),
    .flag_z_o    (fz),
    .flag_v_o    (fv),
    .flag_c_o    (fc),
    .done_o      (done)
  );

  typedef struct {
    logic [31:0] res;
    logic [3:0]  mask;
    logic        x, n, z, v, c;
    string       rtag;
    string       vtag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic x_model = 1'b0;
  bit   ended = 1'b0;

  // bit-serial reference: one position per step
  function automatic exp_t model(input logic [15:0] op, input logic [31:0] a,
                                 input logic [31:0] cr, input logic mode, input logic xin);
    exp_t e;
    int w, cnt;
    logic [31:0] m, val;
    logic left, lg, msb0, sgn, c, vf;
    left = op[8];
    lg   = op[3];
    case (op[7:6])
      2'b00:   begin w = 8;  m = 32'hFF;   e.mask = 4'b0001; end
      2'b01:   begin w = 16; m = 32'hFFFF; e.mask = 4'b0011; end
      2'b10:   begin w = 32; m = '1;       e.mask = 4'b1111; end
      default: begin w = 16; m = 32'hFFFF; e.mask = 4'b0011; end
    endcase
    if (op[7:6] == 2'b11) begin
      cnt = 1;
      e.rtag = "R9";
    end else if (op[5]) begin
      cnt = int'(cr[5:0]);
      e.rtag = (left || lg) ? "R2" : "R6";
    end else begin
      cnt = (op[11:9] == 3'd0) ? 8 : int'(op[11:9]);
      e.rtag = "R1";
    end
    val  = a & m;
    msb0 = val[w-1];
    c    = 1'b0;
    vf   = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (i < cnt) begin
        if (left) begin
          c   = val[w-1];
          val = (val << 1) & m;
          if (val[w-1] != msb0) vf = 1'b1;
        end else begin
          c   = val[0];
          sgn = val[w-1];
          val = val >> 1;
          if (!lg && sgn) val[w-1] = 1'b1;
        end
      end
    end
    e.res  = val;
    e.c    = c;
    e.n    = val[w-1];
    e.z    = (val == 0);
    e.v    = (left && !lg && mode) ? vf : 1'b0;
    e.vtag = (left && !lg && mode) ? "R7" : "R8";
    e.x    = (cnt != 0) ? c : xin;
    return e;
  endfunction

  function automatic logic [15:0] mkop(input logic [2:0] f, input logic left,
                                       input logic [1:0] sz, input logic regc, input logic lg);
    return {4'hE, f, left, sz, regc, 1'b0, lg, 3'b000};
  endfunction

  task automatic send(input logic [15:0] op, input logic [31:0] a,
                      input logic [31:0] cr, input logic mode);
    exp_t e;
    e = model(op, a, cr, mode, x_model);
    x_model = e.x;
    q.push_back(e);
    @(posedge clk);
    #1;
    valid     = 1'b1;
    opcode    = op;
    operand   = a;
    count_reg = cr;
    ovf_mode  = mode;
  endtask

  task automatic idle();
    @(posedge clk);
    #1;
    valid = 1'b0;
  endtask

  task automatic chk1(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !ended && done) begin
      if (q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R10 stray done act=1 exp=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk1(e.rtag, "result", result, e.res);
        chk1("R3", "wmask", {28'b0, wmask}, {28'b0, e.mask});
        chk1("R3", "N", {31'b0, fn}, {31'b0, e.n});
        chk1("R3", "Z", {31'b0, fz}, {31'b0, e.z});
        chk1("R4", "C", {31'b0, fc}, {31'b0, e.c});
        chk1("R5", "X", {31'b0, fx}, {31'b0, e.x});
        chk1(e.vtag, "V", {31'b0, fv}, {31'b0, e.v});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    int n;
    pats[0] = 32'h0000_0000;
    pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8080_8080;
    pats[3] = 32'h7F7F_7F7F;
    pats[4] = 32'h0000_0001;
    pats[5] = 32'hC3A5_965A;
    n = 0;

    repeat (3) @(posedge clk);
    #1;
    // R10: outputs cleared while reset is held
    chk1("R10", "reset result", result, 32'h0);
    chk1("R10", "reset flags", {27'b0, fx, fn, fz, fv, fc}, 32'h0);
    chk1("R10", "reset done", {31'b0, done}, 32'h0);
    chk1("R10", "reset wmask", {28'b0, wmask}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // register counts 0..63 with noise above bit 5 (R2)
    for (int md = 0; md < 2; md++)
      for (int sz = 0; sz < 3; sz++)
        for (int lf = 0; lf < 2; lf++)
          for (int lg = 0; lg < 2; lg++)
            for (int c = 0; c < 64; c++)
              for (int p = 0; p < 6; p++) begin
                send(mkop(3'(c), lf[0], sz[1:0], 1'b1, lg[0]), pats[p],
                     32'hA5A5_A5C0 | 32'(c), md[0]);
                n++;
                if (n % 11 == 0) idle();
              end

    // immediate counts, encoded 0 means 8 (R1)
    for (int md = 0; md < 2; md++)
      for (int sz = 0; sz < 3; sz++)
        for (int lf = 0; lf < 2; lf++)
          for (int lg = 0; lg < 2; lg++)
            for (int f = 0; f < 8; f++)
              for (int p = 0; p < 6; p++)
                send(mkop(3'(f), lf[0], sz[1:0], 1'b0, lg[0]), pats[p], 32'h0000_0003, md[0]);

    // single-bit memory form (R9)
    for (int md = 0; md < 2; md++)
      for (int lf = 0; lf < 2; lf++)
        for (int lg = 0; lg < 2; lg++)
          for (int p = 0; p < 6; p++)
            send(mkop(3'd5, lf[0], 2'b11, 1'b1, lg[0]), pats[p], 32'h0000_0000, md[0]);

    idle();
    for (int i = 0; i < 20; i++) if (q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    if (q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R10 missing done act=%0d exp=0", q.size());
    end
    ended = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule